// File: doc/BRIEF.md
# Full-Scan Chain Controller with Shift-Safe Bus

This block is a small sequential circuit built for structured test. Every state flip-flop is an edge-triggered multiplexed-D scan cell, and all the cells are stitched into one serial chain between a scan input pin and a scan output pin. Two test controls, a test-mode level and a scan-enable level, set the mode. With both low the circuit runs its own function. With both high the chain shifts one position per clock. With test mode high and scan enable low, one clock captures the functional next state into the cells. A test loads a stimulus serially, drives the primary inputs, applies one capture clock and then shifts the response out. The unload of one response shares its shift window with the load of the next stimulus.

The circuit also drives a shared bus from three drivers. In functional operation the state selects at most one driver. While scan enable is high, the enables are overridden so that only driver 0 is on. Shifting walks arbitrary values through the state, so without the override the drivers could contend. A keeper register holds the bus at its last driven value whenever no driver is enabled.

The functional next state is the current state rotated left by one position, XOR the primary inputs. The primary outputs show the state directly.

Top module: `scan_chain_ctl`

## Requirements
- R1: While rst_n is low at a rising clock edge, every scan cell and the bus keeper clear to 0. After reset, po_o is 0, bus_en_o is 000 (with scan_en_i low) and bus_o is 0.
- R2: When scan_en_i is 1 at a rising edge, cell 0 loads scan_in_i and cell i loads the old value of cell i-1. This holds whatever the level of test_mode_i. CHAIN_LEN such edges load a full pattern, and the bit shifted in first ends in cell CHAIN_LEN-1.
- R3: scan_out_o equals cell CHAIN_LEN-1, before each shift edge, whenever test_mode_i is 1. It is 0 whenever test_mode_i is 0.
- R4: When scan_en_i is 0 at a rising edge (normal or capture mode), the state loads {state[CHAIN_LEN-2:0], state[CHAIN_LEN-1]} XOR pi_i.
- R5: po_o equals the current cell contents, with bit i taken from cell i.
- R6: While scan_en_i is 1, bus_en_o is 3'b001, so only driver 0 is enabled, and bus_o equals drv_data_i[BUS_W-1:0].
- R7: While scan_en_i is 0, the functional logic sets bus_en_o from state[1:0] without any change. The code 00 gives 000, 01 gives 001, 10 gives 010 and 11 gives 100. At most one enable is ever high.
- R8: When bus enable bit k is set, bus_o is drv_data_i[k*BUS_W +: BUS_W]. When no enable is set, bus_o holds the value the bus had at the previous rising edge.
- R9: During one shift window of CHAIN_LEN edges, scan_out_o delivers the previously captured response, last cell first. In the same window the next stimulus is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode_i | input | 1 | Test-mode level; enables the scan output |
| scan_en_i | input | 1 | Scan enable: 1 shifts the chain, 0 loads functional data |
| scan_in_i | input | 1 | Serial input to cell 0 |
| scan_out_o | output | 1 | Serial output from the last cell, gated by test mode |
| pi_i | input | CHAIN_LEN | Primary inputs to the functional logic |
| drv_data_i | input | 3*BUS_W | Data of the three bus drivers, driver k at bits k*BUS_W |
| po_o | output | CHAIN_LEN | Primary outputs (state) |
| bus_o | output | BUS_W | Shared bus value |
| bus_en_o | output | 3 | Driver enables, bit k for driver k |

## Verification
The properties assume that the inputs change only between clock edges and that reset is held for at least one edge before checks start. The keeper property also assumes that no driver is enabled in the cycle it compares. The bench drives every input at the falling edge and samples outputs one nanosecond later, so every sampled value is a settled pre-edge value. The sweep covers all four enable codes and pairs each stimulus with different primary inputs and driver data. Each unloaded response is compared against a rotate-and-XOR computed in the bench. Separate passes drive test mode low, to check both the gated scan output and shifting under scan enable alone.

// File: rtl/scan_chain_ctl_pkg.sv
// Package: shared mode type and constants for the scan chain controller.
// Assumes: exactly three bus drivers, selected by a 2-bit state code.
package scan_chain_ctl_pkg;

    localparam int DRV_COUNT = 3;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_ODD     = 2'b01,
        MODE_CAPTURE = 2'b10,
        MODE_SHIFT   = 2'b11
    } scan_mode_e;

    // Map the test-mode and scan-enable levels onto a mode
    function automatic scan_mode_e decode_mode(input logic tm, input logic se);
        return scan_mode_e'({tm, se});
    endfunction

endpackage

// File: rtl/scan_mode_dec.sv
// Module: scan_mode_dec
// Decodes the two test controls into the chain select, the bus override and the
// scan-out enable. Assumes the controls are stable around clock edges.
module scan_mode_dec
    import scan_chain_ctl_pkg::*;
(
    input  logic       test_mode_i,
    input  logic       scan_en_i,
    output scan_mode_e mode_o,
    output logic       cell_shift_o,
    output logic       bus_force_o,
    output logic       so_en_o
);

    scan_mode_e mode;

    // Translate the control pair per the mode table
    always_comb begin
        mode         = decode_mode(test_mode_i, scan_en_i);
        cell_shift_o = 1'b0;
        bus_force_o  = 1'b0;
        so_en_o      = 1'b0;
        unique case (mode)
            MODE_NORMAL:  ;
            MODE_CAPTURE: so_en_o = 1'b1;
            MODE_SHIFT: begin
                cell_shift_o = 1'b1;
                bus_force_o  = 1'b1;
                so_en_o      = 1'b1;
            end
            MODE_ODD: begin
                cell_shift_o = 1'b1;
                bus_force_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mode_o = mode;

endmodule

// File: rtl/scan_cell.sv
// Module: scan_cell
// Edge-triggered multiplexed-D scan cell: the select picks data or scan input.
// Assumes a synchronous active-low reset that clears the cell.
module scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_scan_i,
    input  logic d_i,
    input  logic si_i,
    output logic q_o
);

    // Load the selected input on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else
            q_o <= sel_scan_i ? si_i : d_i;
    end

endmodule

// File: rtl/scan_chain.sv
// Module: scan_chain
// Stitches LEN scan cells into one chain: cell 0 takes the serial input, each later
// cell takes its predecessor, and the last cell feeds the serial output.
// Assumes LEN >= 2.
module scan_chain #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_scan_i,
    input  logic           serial_i,
    input  logic [LEN-1:0] d_i,
    output logic [LEN-1:0] q_o,
    output logic           serial_o
);

    localparam int LAST = LEN - 1;

    logic [LEN-1:0] si_vec;

    // Build the serial path from the input pin and the cell outputs
    always_comb begin
        si_vec[0] = serial_i;
        for (int i = 1; i < LEN; i++)
            si_vec[i] = q_o[i-1];
    end

    for (genvar g = 0; g < LEN; g++) begin : g_cell
        scan_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel_scan_i (sel_scan_i),
            .d_i        (d_i[g]),
            .si_i       (si_vec[g]),
            .q_o        (q_o[g])
        );
    end

    assign serial_o = q_o[LAST];

endmodule

// File: rtl/func_core.sv
// Module: func_core
// Combinational logic of the circuit: next state is the state rotated left by one
// position XOR the primary inputs. The low two state bits pick one bus driver.
// Assumes LEN >= 2.
module func_core
    import scan_chain_ctl_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic [LEN-1:0]       state_i,
    input  logic [LEN-1:0]       pi_i,
    output logic [LEN-1:0]       next_o,
    output logic [DRV_COUNT-1:0] en_fn_o
);

    // Rotate-and-mix next state
    always_comb begin
        next_o = {state_i[LEN-2:0], state_i[LEN-1]} ^ pi_i;
    end

    // Driver choice: code 0 selects none, code k selects driver k-1
    always_comb begin
        en_fn_o = '0;
        for (int k = 0; k < DRV_COUNT; k++)
            if (state_i[1:0] == 2'(k + 1))
                en_fn_o[k] = 1'b1;
    end

endmodule

// File: rtl/bus_unit.sv
// Module: bus_unit
// Shared bus with three drivers, modelled as a select network. The shift-safe
// override turns on driver 0 alone. A keeper register holds the last value when
// no driver is on. Assumes functional enables are at most one-hot.
module bus_unit
    import scan_chain_ctl_pkg::*;
#(
    parameter int W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   force_i,
    input  logic [DRV_COUNT-1:0]   en_fn_i,
    input  logic [DRV_COUNT*W-1:0] drv_data_i,
    output logic [W-1:0]           bus_o,
    output logic [DRV_COUNT-1:0]   en_o
);

    localparam logic [DRV_COUNT-1:0] FORCED_EN = DRV_COUNT'(1);

    logic [W-1:0] keep_q;
    logic [W-1:0] driven;

    // Override enables during shifting, otherwise pass the functional ones
    always_comb begin
        en_o = force_i ? FORCED_EN : en_fn_i;
    end

    // Resolve the bus: enabled driver data, or the kept value
    always_comb begin
        driven = '0;
        for (int k = 0; k < DRV_COUNT; k++)
            if (en_o[k])
                driven = driven | drv_data_i[k*W +: W];
        bus_o = (|en_o) ? driven : keep_q;
    end

    // Keeper follows the bus each cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            keep_q <= '0;
        else
            keep_q <= bus_o;
    end

endmodule

// File: rtl/scan_chain_ctl.sv
// Module: scan_chain_ctl (top)
// Full-scan version of a small sequential circuit: the state is a single scan chain
// controlled by test mode and scan enable, with a shift-safe shared bus.
// Assumes inputs change away from the rising edge; reset is synchronous, active low.
module scan_chain_ctl
    import scan_chain_ctl_pkg::*;
#(
    parameter int CHAIN_LEN = 8,
    parameter int BUS_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       test_mode_i,
    input  logic                       scan_en_i,
    input  logic                       scan_in_i,
    output logic                       scan_out_o,
    input  logic [CHAIN_LEN-1:0]       pi_i,
    input  logic [DRV_COUNT*BUS_W-1:0] drv_data_i,
    output logic [CHAIN_LEN-1:0]       po_o,
    output logic [BUS_W-1:0]           bus_o,
    output logic [DRV_COUNT-1:0]       bus_en_o
);

    scan_mode_e           mode;
    logic                 cell_shift;
    logic                 bus_force;
    logic                 so_en;
    logic [CHAIN_LEN-1:0] state_q;
    logic [CHAIN_LEN-1:0] next_state;
    logic [DRV_COUNT-1:0] en_fn;
    logic                 chain_tail;

    scan_mode_dec u_dec (
        .test_mode_i  (test_mode_i),
        .scan_en_i    (scan_en_i),
        .mode_o       (mode),
        .cell_shift_o (cell_shift),
        .bus_force_o  (bus_force),
        .so_en_o      (so_en)
    );

    func_core #(.LEN(CHAIN_LEN)) u_core (
        .state_i (state_q),
        .pi_i    (pi_i),
        .next_o  (next_state),
        .en_fn_o (en_fn)
    );

    scan_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_scan_i (cell_shift),
        .serial_i   (scan_in_i),
        .d_i        (next_state),
        .q_o        (state_q),
        .serial_o   (chain_tail)
    );

    bus_unit #(.W(BUS_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_i    (bus_force),
        .en_fn_i    (en_fn),
        .drv_data_i (drv_data_i),
        .bus_o      (bus_o),
        .en_o       (bus_en_o)
    );

    // Scan output is quiet outside test mode; the mode is kept for the gating
    always_comb begin
        scan_out_o = (so_en && mode != MODE_NORMAL) ? chain_tail : 1'b0;
    end

    assign po_o = state_q;

endmodule

// File: rtl/scan_chain_ctl_chk.sv
// Module: scan_chain_ctl_chk
// Property checker bound into scan_chain_ctl; observes ports only.
module scan_chain_ctl_chk #(
    parameter int CHAIN_LEN = 8,
    parameter int BUS_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 test_mode_i,
    input logic                 scan_en_i,
    input logic                 scan_in_i,
    input logic                 scan_out_o,
    input logic [CHAIN_LEN-1:0] pi_i,
    input logic [3*BUS_W-1:0]   drv_data_i,
    input logic [CHAIN_LEN-1:0] po_o,
    input logic [BUS_W-1:0]     bus_o,
    input logic [2:0]           bus_en_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> po_o == '0); // R1

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && scan_en_i) |=> (po_o == {$past(po_o[CHAIN_LEN-2:0]), $past(scan_in_i)})); // R2

    AST_SO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode_i |-> scan_out_o == 1'b0); // R3

    AST_SO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode_i |-> scan_out_o == po_o[CHAIN_LEN-1]); // R3

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !scan_en_i) |=>
        (po_o == ({$past(po_o[CHAIN_LEN-2:0]), $past(po_o[CHAIN_LEN-1])} ^ $past(pi_i)))); // R4

    AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en_i |-> (bus_en_o == 3'b001 && bus_o == drv_data_i[BUS_W-1:0])); // R6

    AST_EN_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_en_o)); // R7

    AST_KEEPER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && bus_en_o == 3'b000) |-> bus_o == $past(bus_o)); // R8

endmodule

bind scan_chain_ctl scan_chain_ctl_chk #(.CHAIN_LEN(CHAIN_LEN), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .test_mode_i (test_mode_i),
    .scan_en_i   (scan_en_i),
    .scan_in_i   (scan_in_i),
    .scan_out_o  (scan_out_o),
    .pi_i        (pi_i),
    .drv_data_i  (drv_data_i),
    .po_o        (po_o),
    .bus_o       (bus_o),
    .bus_en_o    (bus_en_o)
);

// File: tb/scan_chain_ctl_bench.sv
// Bench: shift / capture / shift sweep with expected values computed arithmetically.
module scan_chain_ctl_bench;

    localparam int N  = 8;
    localparam int BW = 4;
    localparam int NPAT = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tm, se, si;
    logic          so;
    logic [N-1:0]  pi;
    logic [3*BW-1:0] drv;
    logic [N-1:0]  po;
    logic [BW-1:0] bus;
    logic [2:0]    ben;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    scan_chain_ctl #(.CHAIN_LEN(N), .BUS_W(BW)) u_scan_chain_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .test_mode_i (tm),
        .scan_en_i   (se),
        .scan_in_i   (si),
        .scan_out_o  (so),
        .pi_i        (pi),
        .drv_data_i  (drv),
        .po_o        (po),
        .bus_o       (bus),
        .bus_en_o    (ben)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] step_fn(input logic [N-1:0] s, input logic [N-1:0] p);
        return {s[N-2:0], s[N-1]} ^ p;
    endfunction

    function automatic logic [2:0] en_of(input logic [1:0] c);
        return (c == 2'd0) ? 3'b000 : 3'(1 << (c - 2'd1));
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Shift a full word in while unloading the old content; checks forcing per edge
    task automatic shift_word(input logic [N-1:0] stim, output logic [N-1:0] got);
        got = '0;
        for (int k = 0; k < N; k++) begin
            tm = 1'b1; se = 1'b1; si = stim[N-1-k];
            #1;
            got[N-1-k] = so;
            check("R6 forced enables", 32'(ben), 32'b001);
            check("R6 forced bus", 32'(bus), 32'(drv[BW-1:0]));
            tick();
        end
    endtask

    logic [N-1:0] exp_resp, got, stim, keep_exp;
    logic         have_resp;

    initial begin
        rst_n = 1'b0; tm = 1'b0; se = 1'b0; si = 1'b0;
        pi = 8'hA5; drv = 12'h3C9;
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        #1;
        check("R1 po after reset", 32'(po), 32'h0);
        check("R1 enables after reset", 32'(ben), 32'h0);
        check("R1 bus keeper after reset", 32'(bus), 32'h0);

        have_resp = 1'b0;
        exp_resp  = '0;
        for (int p = 0; p < NPAT; p++) begin
            stim = N'(p * 37 + 5);
            drv  = 12'((p * 293 + 17) & 12'hFFF);
            shift_word(stim, got);
            if (have_resp)
                check("R9 unloaded response", 32'(got), 32'(exp_resp));
            // Stimulus in place, bus enables back to the functional decode
            tm = 1'b1; se = 1'b0; pi = N'(p * 91 + 3);
            #1;
            check("R2 loaded stimulus", 32'(po), 32'(stim));
            check("R5 po shows state", 32'(po), 32'(stim));
            check("R3 scan out is tail", 32'(so), 32'(stim[N-1]));
            check("R7 functional enables", 32'(ben), 32'(en_of(stim[1:0])));
            if (stim[1:0] == 2'd0)
                keep_exp = N'(drv[BW-1:0]);
            else
                keep_exp = N'(drv[(int'(stim[1:0]) - 1) * BW +: BW]);
            check("R8 bus value", 32'(bus), 32'(keep_exp));
            exp_resp = step_fn(stim, pi);
            tick();
            check("R4 capture result", 32'(po), 32'(exp_resp));
            have_resp = 1'b1;
        end
        shift_word('0, got);
        check("R9 final unload", 32'(got), 32'(exp_resp));

        // Normal mode: scan out quiet, state evolves functionally
        tm = 1'b0; se = 1'b0;
        stim = po;
        for (int c = 0; c < 6; c++) begin
            pi = N'(c * 53 + 11);
            #1;
            check("R3 scan out quiet in normal mode", 32'(so), 32'h0);
            check("R7 enables in normal mode", 32'(ben), 32'(en_of(stim[1:0])));
            stim = step_fn(stim, pi);
            tick();
            check("R4 normal step", 32'(po), 32'(stim));
        end

        // Keeper with drivers changing: force state code 00 via the chain
        shift_word(8'hF0, got);
        tm = 1'b1; se = 1'b0;
        keep_exp = N'(drv[BW-1:0]);
        drv = ~drv;
        #1;
        check("R8 keeper holds across driver change", 32'(bus), 32'(keep_exp));

        // Scan enable alone still shifts; scan out stays quiet
        tm = 1'b0;
        stim = po;
        for (int k = 0; k < 3; k++) begin
            se = 1'b1; si = k[0];
            #1;
            check("R3 scan out quiet while shifting", 32'(so), 32'h0);
            stim = {stim[N-2:0], si};
            tick();
            check("R2 shift without test mode", 32'(po), 32'(stim));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule